// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital controller of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A one-cycle start request together with a 3-bit channel number begins a conversion. The block latches the channel, drives the channel-select lines and a sample-enable strobe, and then runs a binary search. It presents a trial code to an external DAC and reads back one comparator bit per trial. When the search is over it loads the 8-bit result register and raises a one-cycle done flag.

All timing comes from an internal conversion clock equal to the system clock divided by four. Every conversion spends a fixed budget of 31 conversion-clock periods. The first 10 are sampling. Then come eight trials of two periods each, MSB first. The remaining five periods let the last decision settle before the result is latched. A conversion is therefore always 124 system clocks long, whatever the data. Only single-shot operation is offered, and a busy output covers the whole conversion.

Top module: `sar_adc_seq`

## Requirements
- R1: While reset is held and right after it, busy, done and sample-enable are low, and both the trial code and the result are zero.
- R2: A start request sampled on a clock edge while idle is accepted. After that edge busy and sample-enable are high.
- R3: The done pulse comes exactly 124 system clocks (31 periods of the clock divided by four) after the accepting edge.
- R4: Sample-enable stays high for the first 40 system clocks (10 conversion periods) after the accepting edge and is low from the 40th edge on.
- R5: When sampling ends, the trial code is 0x80. Each trial lasts two conversion periods. At the end of a trial the bit under test is kept when the comparator bit is 1 (input at or above the trial code) and cleared when it is 0. The next lower bit is set in the same step, so the second trial code is (input & 0x80) | 0x40.
- R6: With an ideal comparator the result equals the 8-bit input code, including the end values 0x00 and 0xFF.
- R7: Done is high for exactly one clock. Busy falls and the result updates on the same edge. The result then holds until the next done.
- R8: A start request that arrives while busy is ignored. The running conversion keeps its timing and its channel.
- R9: The channel number is latched on the accepting edge. Changes on the channel input during a conversion do not reach the channel-select output.
- R10: The channel-select output equals the 3-bit channel input given with the accepted start, so any of the eight channels can be chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled on the clock edge |
| chan_i | input | 3 | Channel number requested with start |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the trial code |
| chan_sel_o | output | 3 | Latched channel select to the analog multiplexer |
| sample_en_o | output | 1 | Sample-and-hold enable |
| dac_code_o | output | 8 | Trial code for the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | One-clock pulse when the result updates |

## Verification
The assertions take the comparator to be a settled, clock-synchronous function of the selected input and the trial code. They also take start to be a level the bench drives between edges, with no relation to the conversion clock phase. The bench models an ideal comparator combinationally from the latched channel and the trial code. It drives start and the channel only on falling edges, and it gives the unselected channels the complement of the target code, so that a wrong channel shows up in the result. Disturbing starts and channel changes are issued only while busy is already high, well away from the accepting and finishing edges.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // True while the conversion period index lies inside the sampling window.
  function automatic bit in_sample(input int period, input int sample_len);
    return period < sample_len;
  endfunction

  // True on the period that closes a bit trial (the decision point).
  function automatic bit is_decide(input int period, input int sample_len,
                                   input int trial_len, input int res);
    int off;
    off = period - sample_len;
    if (off < 0 || off >= res * trial_len) return 1'b0;
    return (off % trial_len) == (trial_len - 1);
  endfunction

  // Trial number (0 = MSB) for a period inside the trial window.
  function automatic int trial_slot(input int period, input int sample_len,
                                    input int trial_len);
    if (period < sample_len) return 0;
    return (period - sample_len) / trial_len;
  endfunction

  // Total system clocks in one conversion.
  function automatic int conv_clocks(input int div, input int periods);
    return div * periods;
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_timeline.sv
module sar_timeline
  import sar_pkg::*;
#(
  parameter int RES        = 8,
  parameter int SAMPLE_LEN = 10,
  parameter int TRIAL_LEN  = 2,
  parameter int TOTAL_LEN  = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch,
  input  logic                       tick,
  output logic                       busy,
  output logic                       sampling,
  output logic                       load_msb,
  output logic                       decide,
  output logic [$clog2(RES)-1:0]     bit_idx,
  output logic                       last
);
  localparam int PW = $clog2(TOTAL_LEN);
  localparam int IW = $clog2(RES);
  localparam logic [PW-1:0] P_END    = PW'(TOTAL_LEN - 1);
  localparam logic [PW-1:0] P_SAMPLE = PW'(SAMPLE_LEN - 1);

  logic [PW-1:0] period;

  assign sampling = busy && in_sample(int'(period), SAMPLE_LEN);
  assign load_msb = busy && tick && (period == P_SAMPLE);
  assign decide   = busy && tick &&
                    is_decide(int'(period), SAMPLE_LEN, TRIAL_LEN, RES);
  assign bit_idx  = IW'(trial_slot(int'(period), SAMPLE_LEN, TRIAL_LEN));
  assign last     = busy && tick && (period == P_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      period <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      period <= '0;
    end else if (busy && tick) begin
      if (period == P_END) begin
        busy   <= 1'b0;
        period <= '0;
      end else begin
        period <= period + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int RES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   load_msb,
  input  logic                   decide,
  input  logic [$clog2(RES)-1:0] bit_idx,
  input  logic                   cmp,
  output logic [RES-1:0]         code
);
  localparam int IW = $clog2(RES);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  // Drop the tested bit when the input is below the code, then arm the next one.
  function automatic logic [RES-1:0] refine(input logic [RES-1:0] c,
                                            input logic [IW-1:0] idx,
                                            input logic keep);
    logic [RES-1:0] r;
    int pos;
    r   = c;
    pos = RES - 1 - int'(idx);
    for (int b = 0; b < RES; b++) begin
      if (b == pos && !keep) r[b] = 1'b0;
      if (b == pos - 1)      r[b] = 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code <= '0;
    else if (clear)    code <= '0;
    else if (load_msb) code <= MSB_ONLY;
    else if (decide)   code <= refine(code, bit_idx, cmp);
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_BITS       = 8,
  parameter int CH_COUNT       = 8,
  parameter int CH_W           = $clog2(CH_COUNT),
  parameter int CLK_DIV        = 4,
  parameter int SAMPLE_PERIODS = 10,
  parameter int TRIAL_PERIODS  = 2,
  parameter int TOTAL_PERIODS  = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                cmp_i,
  output logic [CH_W-1:0]     chan_sel_o,
  output logic                sample_en_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);
  localparam int IW        = $clog2(RES_BITS);
  localparam int TAIL_LEN  = TOTAL_PERIODS - SAMPLE_PERIODS - RES_BITS * TRIAL_PERIODS;

  // Named internal events, visible to the bound checker.
  logic          launch;
  logic          conv_tick;
  logic          load_msb;
  logic          decide;
  logic          conv_last;
  logic [IW-1:0] bit_idx;
  logic          busy;
  logic          sampling;
  logic [RES_BITS-1:0] code;

  assign launch = start_i && !busy && (TAIL_LEN >= 1);

  sar_prescaler #(.DIV(CLK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .clear (launch),
    .tick  (conv_tick)
  );

  sar_timeline #(
    .RES        (RES_BITS),
    .SAMPLE_LEN (SAMPLE_PERIODS),
    .TRIAL_LEN  (TRIAL_PERIODS),
    .TOTAL_LEN  (TOTAL_PERIODS)
  ) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .tick     (conv_tick),
    .busy     (busy),
    .sampling (sampling),
    .load_msb (load_msb),
    .decide   (decide),
    .bit_idx  (bit_idx),
    .last     (conv_last)
  );

  sar_register #(.RES(RES_BITS)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .load_msb (load_msb),
    .decide   (decide),
    .bit_idx  (bit_idx),
    .cmp      (cmp_i),
    .code     (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chan_sel_o <= '0;
    else if (launch) chan_sel_o <= chan_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= conv_last;
      if (conv_last) result_o <= code;
    end
  end

  assign busy_o      = busy;
  assign sample_en_o = sampling;
  assign dac_code_o  = code;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_BITS       = 8,
  parameter int CH_W           = 3,
  parameter int CLK_DIV        = 4,
  parameter int TOTAL_PERIODS  = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                sample_en_o,
  input logic                conv_last,
  input logic [CH_W-1:0]     chan_sel_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [RES_BITS-1:0] result_o
);
  localparam int LEN = sar_pkg::conv_clocks(CLK_DIV, TOTAL_PERIODS);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)             run_cnt <= run_cnt + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!busy_o && !done_o && !sample_en_o)); // R1
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> (busy_o && sample_en_o)); // R2
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (run_cnt == 16'(LEN))); // R3
  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sample_en_o |-> busy_o); // R4
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ($fell(sample_en_o) && busy_o) |-> (dac_code_o == MSB_ONLY)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o)); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (start_i && busy_o && !conv_last) |=> busy_o); // R8
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(chan_sel_o)); // R9
endmodule

bind sar_adc_seq sar_adc_seq_chk #(
  .RES_BITS      (RES_BITS),
  .CH_W          (CH_W),
  .CLK_DIV       (CLK_DIV),
  .TOTAL_PERIODS (TOTAL_PERIODS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sample_en_o (sample_en_o),
  .conv_last   (conv_last),
  .chan_sel_o  (chan_sel_o),
  .dac_code_o  (dac_code_o),
  .result_o    (result_o)
);

// File: tb/sim_sar_adc_seq.sv
module sim_sar_adc_seq;
  localparam int CONV_LEN = 124;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] chan_i = '0;
  logic       cmp_i;
  logic [2:0] chan_sel_o;
  logic       sample_en_o;
  logic [7:0] dac_code_o;
  logic       busy_o;
  logic [7:0] result_o;
  logic       done_o;

  logic [7:0] vin [8];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { int ch; int val; int t0; } exp_t;
  exp_t sbq[$];
  exp_t got;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Ideal comparator on the latched channel.
  assign cmp_i = (vin[chan_sel_o] >= dac_code_o);

  sar_adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .cmp_i(cmp_i),
    .chan_sel_o(chan_sel_o), .sample_en_o(sample_en_o), .dac_code_o(dac_code_o),
    .busy_o(busy_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pop expected item on each done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 done without request", 1, 0);
      end else begin
        got = sbq.pop_front();
        chk(result_o == got.val[7:0], "R6 result", result_o, got.val);
        chk(cyc - got.t0 == CONV_LEN, "R3 length", cyc - got.t0, CONV_LEN);
        chk(!busy_o, "R7 busy low at done", busy_o, 0);
        chk(chan_sel_o == got.ch[2:0], "R9 channel at done", chan_sel_o, got.ch);
      end
    end
  end

  task automatic conv(input int c, input logic [7:0] v, input bit disturb);
    exp_t e;
    for (int i = 0; i < 8; i++) vin[i] = (i == c) ? v : ~v;
    @(negedge clk);
    start_i = 1'b1;
    chan_i  = c[2:0];
    @(negedge clk);
    start_i = 1'b0;
    e.ch = c; e.val = v; e.t0 = cyc;
    sbq.push_back(e);
    chk(busy_o && sample_en_o, "R2 accepted", {busy_o, sample_en_o}, 3);
    chk(chan_sel_o == c[2:0], "R10 channel select", chan_sel_o, c);
    for (int k = 1; k <= CONV_LEN + 1; k++) begin
      @(negedge clk);
      if (k == 39) chk(sample_en_o, "R4 sampling still on", sample_en_o, 1);
      if (k == 40) begin
        chk(!sample_en_o, "R4 sampling off", sample_en_o, 0);
        chk(dac_code_o == 8'h80, "R5 first trial", dac_code_o, 8'h80);
      end
      if (k == 48)
        chk(dac_code_o == {v[7], 1'b1, 6'b0}, "R5 second trial", dac_code_o, {v[7], 1'b1, 6'b0});
      if (k == 60 && disturb) begin
        start_i = 1'b1;
        chan_i  = ~c[2:0];
      end
      if (k == 61) start_i = 1'b0;
      if (k == 70 && disturb) begin
        chk(busy_o, "R8 still busy", busy_o, 1);
        chk(chan_sel_o == c[2:0], "R9 channel held", chan_sel_o, c);
        chk(dac_code_o[7] == v[7], "R8 no restart", dac_code_o[7], v[7]);
      end
      if (k == CONV_LEN + 1) begin
        chk(!done_o, "R7 single pulse", done_o, 0);
        chk(result_o == v, "R7 result held", result_o, v);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !sample_en_o, "R1 flags in reset", {busy_o, done_o, sample_en_o}, 0);
    chk(dac_code_o == 0 && result_o == 0, "R1 data in reset", {dac_code_o, result_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && dac_code_o == 0, "R1 idle after reset", busy_o, 0);
    conv(3, 8'h5A, 1'b0);
    conv(0, 8'h00, 1'b0);
    conv(7, 8'hFF, 1'b0);
    conv(1, 8'h80, 1'b0);
    conv(2, 8'h7F, 1'b0);
    conv(5, 8'h01, 1'b0);
    conv(6, 8'hFE, 1'b0);
    conv(4, 8'hA5, 1'b1);
    conv(2, 8'h3C, 1'b1);
    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R3 all results seen", sbq.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule